// File: doc/BRIEF.md
# Short-Circuit Restart and Diagnostic Sequencer

This block supervises four amplifier output channels after their short-circuit protection trips. Each channel has its own controller. It switches the channel's output stage off when the channel's trip input rises and brings it back on a 1 ms grid once the overload has gone. All time is counted in ticks of a 1 ms strobe input.

When diagnostics are enabled, a trip is confirmed at the next tick before any long measurement starts. A confirmed overload starts a diagnostic cycle that lasts a parameterised number of ticks. During the cycle the controller collects the fault classes reported by the analog sensing. It keeps only the classes that held at every sampled tick, resolves combinations with a fixed priority, and latches the outcome as that channel's result. The channel then behaves as in plain restart mode. A channel stores one result per host status read: after it stores, a further cycle on that channel is allowed only once a read strobe arrives.

The host marks whether a measurement belongs to the turn-on test or to permanent monitoring. Open-load detection is only meaningful in the turn-on test.

Top module: `short_restart_diag`

## Requirements
- R1: After reset every channel output (`chanOn`) is 1 and every `resValid` is 0.
- R2: With `diagEn` low, a channel whose `trip` is high turns off in the next clock. It stays off until a clock edge on which `msTick` is high and `trip` is low, and it turns on right after that edge.
- R3: A trip on one channel does not change `chanOn` of any other channel.
- R4: With `diagEn` high and the channel armed, a trip turns the channel off. If `trip` is low at the next `msTick` edge, the channel turns back on after that edge and no result is stored.
- R5: If `trip` is still high at that first tick, a diagnostic cycle starts. The result is stored on the CYCLE_TICKS-th tick edge after the confirming tick. The channel stays off through the cycle and afterwards follows the R2 restart rule.
- R6: After a channel stores a result it is disarmed. Its trips then follow R2 and its result does not change, until a `statusRead` pulse re-arms all channels. Reset leaves every channel armed.
- R7: A fault class is reported only if its input was high at the confirming tick and at every tick of the cycle.
- R8: Priority of stable faults: short to supply (`resSupply`) suppresses shorted load and open load. Any short to ground suppresses shorted load. A source-side ground short together with a supply short reports both. A sink-side ground short together with a supply short reports supply only. A sink-side ground short together with an open load reports open load only. A shorted load suppresses open load.
- R9: `resPerm` is the inverse of `turnOnTest` at the storing edge. When it is 1, an open load is never reported.
- R10: If `diagEn` falls during a confirm or a cycle, the channel goes to restart behaviour in the next clock without storing a result, and it stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-clock strobe every 1 ms |
| diagEn | input | 1 | Diagnostic mode enable |
| turnOnTest | input | 1 | 1 while the turn-on test is running, 0 for permanent monitoring |
| statusRead | input | 1 | One-clock strobe when the host finishes a status read |
| trip | input | 4 | Per-channel protection trip (overload present) |
| fltGndSrc | input | 4 | Short to ground on the source-side output |
| fltGndSnk | input | 4 | Short to ground on the sink-side output |
| fltSupply | input | 4 | Short to supply |
| fltLoad | input | 4 | Short across the load |
| fltOpen | input | 4 | Open load |
| chanOn | output | 4 | Channel output stage enabled |
| resValid | output | 4 | A result has been stored |
| resPerm | output | 4 | Stored result came from permanent monitoring |
| resGnd | output | 4 | Stored short to ground |
| resSupply | output | 4 | Stored short to supply |
| resLoad | output | 4 | Stored shorted load |
| resOpen | output | 4 | Stored open load |

## Verification
The assertions assume that `msTick` is a single-clock pulse and that `statusRead` never coincides with a storing tick. They also assume that the fault-class inputs are synchronous and only meaningful while a channel is tripped. The stimulus drives every input on the falling clock edge and generates ticks every eight clocks. It issues the read strobe only while all channels are idle, and it changes fault classes only between ticks, so each sampled tick sees one defined fault set.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_RETRY,
    ST_CONFIRM,
    ST_DIAG
  } chState_t;

  typedef struct packed {
    logic gndSrc;
    logic gndSnk;
    logic supply;
    logic load;
    logic open;
  } faultSet_t;

  typedef struct packed {
    logic valid;
    logic perm;
    logic gnd;
    logic supply;
    logic load;
    logic open;
  } diagRes_t;

  typedef struct packed {
    logic load;
    logic accum;
    logic store;
  } dpStrobe_t;

  // fixed double-fault priority
  function automatic diagRes_t resolveFaults(faultSet_t f, logic perm);
    diagRes_t r;
    logic olSeen;
    olSeen   = f.open & ~perm;
    r.valid  = 1'b1;
    r.perm   = perm;
    r.supply = f.supply;
    r.gnd    = f.gndSrc | (f.gndSnk & ~f.supply & ~olSeen);
    r.load   = f.load & ~f.supply & ~f.gndSrc & ~f.gndSnk;
    r.open   = olSeen & ~f.supply & ~f.gndSrc & ~f.load;
    return r;
  endfunction

endpackage

// File: rtl/srd_ctrl.sv
module srd_ctrl
  import srd_pkg::*;
#(
  parameter int CYCLE_TICKS = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      msTick,
  input  logic      diagEn,
  input  logic      statusRead,
  input  logic      trip,
  output logic      chanOn,
  output dpStrobe_t strobe
);

  localparam int CNT_W = (CYCLE_TICKS > 1) ? $clog2(CYCLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_TICKS - 1);

  chState_t state, stateNext;
  logic [CNT_W-1:0] tickCnt;
  logic armed;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (trip) stateNext = (diagEn && armed) ? ST_CONFIRM : ST_RETRY;
      end
      ST_RETRY: begin
        if (msTick && !trip) stateNext = ST_RUN;
      end
      ST_CONFIRM: begin
        if (!diagEn) stateNext = ST_RETRY;
        else if (msTick) begin
          if (!trip) stateNext = ST_RUN;
          else begin
            stateNext   = ST_DIAG;
            strobe.load = 1'b1;
          end
        end
      end
      ST_DIAG: begin
        if (!diagEn) stateNext = ST_RETRY;
        else if (msTick) begin
          if (tickCnt == LAST_CNT) begin
            strobe.store = 1'b1;
            stateNext    = ST_RETRY;
          end else begin
            strobe.accum = 1'b1;
          end
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      tickCnt <= '0;
      armed   <= 1'b1;
    end else begin
      state <= stateNext;
      if (strobe.load) tickCnt <= '0;
      else if (strobe.accum) tickCnt <= tickCnt + 1'b1;
      if (strobe.store) armed <= 1'b0;
      else if (statusRead) armed <= 1'b1;
    end
  end

  assign chanOn = (state == ST_RUN);

  // R2: a channel only comes back on a tick edge
  assert_restart_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanOn) |-> $past(msTick));

  // R4: a cleared overload at the confirming tick resumes the channel
  assert_confirm_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM && diagEn && msTick && !trip) |=> chanOn);

  // R6: a result is only stored while armed
  assert_store_armed_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |-> armed);

  // R10: dropping diagnostics aborts to restart
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DIAG && !diagEn) |=> (state == ST_RETRY && !chanOn));

endmodule

// File: rtl/srd_data.sv
module srd_data
  import srd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  faultSet_t faults,
  input  logic      perm,
  input  dpStrobe_t strobe,
  output diagRes_t  result
);

  faultSet_t acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      result <= '0;
    end else begin
      if (strobe.load) acc <= faults;
      else if (strobe.accum) acc <= faultSet_t'(acc & faults);
      if (strobe.store) result <= resolveFaults(faultSet_t'(acc & faults), perm);
    end
  end

  // R6: result holds between stores
  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.store |=> $stable(result));

  // R8: a shorted load never coexists with a supply or ground short
  assert_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
    result.valid |-> !(result.load && (result.supply || result.gnd)));

  // R9: permanent results never flag open load
  assert_open_perm_R9: assert property (@(posedge clk) disable iff (!rstN)
    (result.valid && result.perm) |-> !result.open);

endmodule

// File: rtl/short_restart_diag.sv
module short_restart_diag
  import srd_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CYCLE_TICKS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              diagEn,
  input  logic              turnOnTest,
  input  logic              statusRead,
  input  logic [NUM_CH-1:0] trip,
  input  logic [NUM_CH-1:0] fltGndSrc,
  input  logic [NUM_CH-1:0] fltGndSnk,
  input  logic [NUM_CH-1:0] fltSupply,
  input  logic [NUM_CH-1:0] fltLoad,
  input  logic [NUM_CH-1:0] fltOpen,
  output logic [NUM_CH-1:0] chanOn,
  output logic [NUM_CH-1:0] resValid,
  output logic [NUM_CH-1:0] resPerm,
  output logic [NUM_CH-1:0] resGnd,
  output logic [NUM_CH-1:0] resSupply,
  output logic [NUM_CH-1:0] resLoad,
  output logic [NUM_CH-1:0] resOpen
);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    dpStrobe_t strobe;
    faultSet_t faults;
    diagRes_t  result;

    assign faults = '{gndSrc: fltGndSrc[g], gndSnk: fltGndSnk[g],
                      supply: fltSupply[g], load: fltLoad[g], open: fltOpen[g]};

    srd_ctrl #(.CYCLE_TICKS(CYCLE_TICKS)) i_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .msTick     (msTick),
      .diagEn     (diagEn),
      .statusRead (statusRead),
      .trip       (trip[g]),
      .chanOn     (chanOn[g]),
      .strobe     (strobe)
    );

    srd_data i_data (
      .clk    (clk),
      .rstN   (rstN),
      .faults (faults),
      .perm   (!turnOnTest),
      .strobe (strobe),
      .result (result)
    );

    assign resValid[g]  = result.valid;
    assign resPerm[g]   = result.perm;
    assign resGnd[g]    = result.gnd;
    assign resSupply[g] = result.supply;
    assign resLoad[g]   = result.load;
    assign resOpen[g]   = result.open;
  end

endmodule

// File: tb/test_short_restart_diag.sv
module test_short_restart_diag;

  localparam int NCH = 4;
  localparam int CYC = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic diagEn = 1'b0;
  logic turnOnTest = 1'b0;
  logic statusRead = 1'b0;
  logic [NCH-1:0] trip = '0, fltGndSrc = '0, fltGndSnk = '0;
  logic [NCH-1:0] fltSupply = '0, fltLoad = '0, fltOpen = '0;
  logic [NCH-1:0] chanOn, resValid, resPerm, resGnd, resSupply, resLoad, resOpen;

  int checks = 0;
  int errors = 0;
  int tickDiv = 0;

  typedef struct {
    int         ch;
    logic [5:0] val;
    string      req;
  } expItem_t;
  expItem_t expQ[$];
  logic [5:0] prevRes [NCH];

  short_restart_diag #(.NUM_CH(NCH), .CYCLE_TICKS(CYC)) i_short_restart_diag (
    .clk(clk), .rstN(rstN), .msTick(msTick), .diagEn(diagEn),
    .turnOnTest(turnOnTest), .statusRead(statusRead), .trip(trip),
    .fltGndSrc(fltGndSrc), .fltGndSnk(fltGndSnk), .fltSupply(fltSupply),
    .fltLoad(fltLoad), .fltOpen(fltOpen), .chanOn(chanOn), .resValid(resValid),
    .resPerm(resPerm), .resGnd(resGnd), .resSupply(resSupply),
    .resLoad(resLoad), .resOpen(resOpen)
  );

  always #10 clk = ~clk;

  // 1 ms tick every eight clocks
  always @(negedge clk) begin
    tickDiv = (tickDiv == 7) ? 0 : tickDiv + 1;
    msTick  = (tickDiv == 7);
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    repeat (n) @(posedge clk iff msTick);
    @(negedge clk);
  endtask

  // result vector {valid, perm, gnd, supply, load, open}
  function automatic logic [5:0] resOf(int c);
    return {resValid[c], resPerm[c], resGnd[c], resSupply[c], resLoad[c], resOpen[c]};
  endfunction

  task automatic expectStore(int c, logic [5:0] v, string req);
    expItem_t it;
    it.ch = c; it.val = v; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NCH; c++) begin
        if (resOf(c) !== prevRes[c]) begin
          if (expQ.size() == 0) begin
            check("R6 unexpected store", int'(resOf(c)), int'(prevRes[c]));
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check({it.req, " channel"}, c, it.ch);
            check(it.req, int'(resOf(c)), int'(it.val));
          end
          prevRes[c] = resOf(c);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) prevRes[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 chanOn", int'(chanOn), 'hF);
    check("R1 resValid", int'(resValid), 0);

    // R2 / R3 restart mode
    waitTicks(1);
    trip[0] = 1'b1;
    @(negedge clk);
    check("R2 off", int'(chanOn), 'hE);
    check("R3 others on", int'(chanOn[3:1]), 'h7);
    waitTicks(2);
    check("R2 still off", int'(chanOn[0]), 0);
    trip[0] = 1'b0;
    @(negedge clk);
    check("R2 waits for grid", int'(chanOn[0]), 0);
    waitTicks(1);
    check("R2 restart", int'(chanOn[0]), 1);

    // R4 quick clear
    diagEn = 1'b1;
    trip[1] = 1'b1;
    @(negedge clk);
    check("R4 off", int'(chanOn[1]), 0);
    trip[1] = 1'b0;
    waitTicks(1);
    check("R4 resumed", int'(chanOn[1]), 1);
    check("R4 no result", int'(resValid[1]), 0);

    // R5 / R8 full cycle on channel 2, permanent
    fltSupply[2] = 1'b1; fltLoad[2] = 1'b1; fltGndSrc[2] = 1'b1;
    expectStore(2, 6'b111100, "R8 supply+srcgnd");
    trip[2] = 1'b1;
    waitTicks(1);
    check("R5 off in cycle", int'(chanOn[2]), 0);
    waitTicks(CYC - 1);
    check("R5 not yet stored", int'(resValid[2]), 0);
    waitTicks(1);
    check("R5 stored", int'(resValid[2]), 1);
    check("R5 off after", int'(chanOn[2]), 0);
    trip[2] = 1'b0; fltSupply[2] = 1'b0; fltLoad[2] = 1'b0; fltGndSrc[2] = 1'b0;
    waitTicks(1);
    check("R5 restart", int'(chanOn[2]), 1);

    // R6 disarmed channel follows restart only
    fltLoad[2] = 1'b1;
    trip[2] = 1'b1;
    waitTicks(CYC + 2);
    check("R6 off", int'(chanOn[2]), 0);
    trip[2] = 1'b0; fltLoad[2] = 1'b0;
    waitTicks(1);
    check("R6 restart", int'(chanOn[2]), 1);
    check("R6 result kept", int'(resOf(2)), 'b111100);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;

    // R7 / R8 turn-on test on channel 3; load drops once
    turnOnTest = 1'b1;
    fltGndSnk[3] = 1'b1; fltOpen[3] = 1'b1; fltLoad[3] = 1'b1;
    expectStore(3, 6'b100001, "R7 unstable load dropped, R8 open over sink gnd");
    trip[3] = 1'b1;
    waitTicks(1);
    waitTicks(40);
    fltLoad[3] = 1'b0;
    waitTicks(1);
    fltLoad[3] = 1'b1;
    waitTicks(CYC - 41);
    check("R7 stored", int'(resValid[3]), 1);
    trip[3] = 1'b0; fltGndSnk[3] = 1'b0; fltOpen[3] = 1'b0; fltLoad[3] = 1'b0;
    turnOnTest = 1'b0;
    waitTicks(1);

    // R9 open load masked in permanent monitoring
    fltOpen[0] = 1'b1;
    expectStore(0, 6'b110000, "R9 open masked");
    trip[0] = 1'b1;
    waitTicks(1 + CYC);
    check("R9 perm flag", int'(resPerm[0]), 1);
    trip[0] = 1'b0; fltOpen[0] = 1'b0;
    waitTicks(1);

    // R10 abort keeps channel armed
    fltLoad[1] = 1'b1;
    trip[1] = 1'b1;
    waitTicks(1);
    waitTicks(20);
    diagEn = 1'b0;
    @(negedge clk);
    check("R10 off after abort", int'(chanOn[1]), 0);
    check("R10 no store", int'(resValid[1]), 0);
    diagEn = 1'b1;
    trip[1] = 1'b0; fltLoad[1] = 1'b0;
    waitTicks(1);
    check("R10 restart", int'(chanOn[1]), 1);
    fltSupply[1] = 1'b1; fltGndSnk[1] = 1'b1;
    expectStore(1, 6'b110100, "R10 still armed, R8 supply over sink gnd");
    trip[1] = 1'b1;
    waitTicks(1 + CYC);
    trip[1] = 1'b0; fltSupply[1] = 1'b0; fltGndSnk[1] = 1'b0;
    waitTicks(1);
    check("R10 back on", int'(chanOn[1]), 1);

    check("R6 all expected stores seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule